// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and a short global register of the most recent branch outcomes. A counter is chosen by joining low-order bits of the branch address with the global outcome pattern, so one branch owns several counters and the recent path through the program decides which of them speaks.

A fetch stage presents a branch address on the lookup port and gets a taken or not-taken guess combinationally, in the same cycle. When the branch later resolves, the execute stage presents its address and real direction on the training port. On that clock edge the selected counter moves one step toward the outcome and the outcome is shifted into the global register. Different branches that land on the same table slot share it silently.

Top module: `corr_branch_predictor`

## Requirements
- R1: A synchronous active-low reset sets every counter to weak not-taken (encoding 01) and clears the global register to 00, so every lookup after reset answers not-taken.
- R2: The guess is the high bit of the counter at index {pc[9:2], hist[1:0]} with the default parameters, where hist is the global register.
- R3: A taken training event raises the selected counter by one (00, 01, 10, 11 meaning strong not-taken, weak not-taken, weak taken, strong taken) and leaves it at 11 when it is already 11.
- R4: A not-taken training event lowers the selected counter by one and leaves it at 00 when it is already 00.
- R5: A counter at strong taken keeps predicting taken after one not-taken event and predicts not-taken only after a second one.
- R6: Each training event shifts its outcome into the global register: the new value is {old hist[0], outcome}, with bit 0 holding the newest outcome.
- R7: A training event changes only the counter selected by its address and the current history; counters of the same address under other history patterns keep their values.
- R8: When a lookup and a training event occur in the same cycle, the guess uses the counter and history values from before that event.
- R9: Address bits 1:0 and bits above bit 9 take no part in the index, so addresses that differ only there share counters.
- R10: With the training valid input low, neither the counters nor the global register change, whatever the other training inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lookup_pc | input | PC_W (32) | Address of the branch being fetched |
| lookup_taken | output | 1 | Guessed direction, 1 = taken |
| train_valid | input | 1 | A resolved branch is presented this cycle |
| train_pc | input | PC_W (32) | Address of the resolved branch |
| train_taken | input | 1 | Real direction of the resolved branch |

## Verification
The bench drives a single branch through every history pattern so that the path-dependent choice of counter is visible: a design that indexes by address alone, or shifts the history in the wrong direction, answers from the wrong counter and the guesses diverge from the hand-worked sequence. Saturation at both ends and the two-miss hysteresis are driven explicitly; a counter that wraps would flip after a single miss or come out of the bottom as taken. Same-cycle lookup and training checks that the guess is read before the edge, and idle cycles with live training data check that a design ignoring the valid input would disturb a known counter. Addresses that differ only in the low two bits or above bit 9 must alias, while one differing in bit 2 must not.

// File: rtl/cbp_pkg.sv
// Shared encodings and counter arithmetic for the correlating predictor.
// Assumes 2-bit counters; the high bit of a counter is its guess.
package cbp_pkg;

    localparam int CTR_W = 2;

    localparam logic [CTR_W-1:0] CTR_STRONG_NT = 2'b00;
    localparam logic [CTR_W-1:0] CTR_WEAK_NT   = 2'b01;
    localparam logic [CTR_W-1:0] CTR_WEAK_T    = 2'b10;
    localparam logic [CTR_W-1:0] CTR_STRONG_T  = 2'b11;

    // Move a counter one step toward the outcome, stopping at the ends.
    function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] cur,
                                                  input logic             taken);
        logic [CTR_W-1:0] nxt;
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cbp_history.sv
// Global outcome shift register.
// Bit 0 always holds the most recent outcome; shifts only when enabled.
module cbp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist_q
);

    logic [HIST_W-1:0] hist_next;

    // Form the shifted value with the newest outcome entering at bit 0.
    generate
        if (HIST_W == 1) begin : g_single
            assign hist_next = outcome;
        end else begin : g_multi
            assign hist_next = {hist_q[HIST_W-2:0], outcome};
        end
    endgenerate

    // Hold, clear or shift the history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_next;
        end
    end

endmodule

// File: rtl/cbp_index.sv
// Combinational index former: word-address bits of the PC joined with the
// global history. Assumes instructions are 4-byte aligned (bits 1:0 dropped).
module cbp_index #(
    parameter int PC_W     = 32,
    parameter int SET_BITS = 8,
    parameter int HIST_W   = 2,
    localparam int IDX_W   = SET_BITS + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    localparam int SET_LO = 2;
    localparam int SET_HI = SET_LO + SET_BITS - 1;

    // Address set bits take the upper part, history the lower part.
    assign idx = {pc[SET_HI:SET_LO], hist};

    // Bits outside the set field are deliberately not used (aliasing).
    logic unused_pc_bits;
    generate
        if (PC_W > SET_HI + 1) begin : g_upper
            assign unused_pc_bits = ^{pc[PC_W-1:SET_HI+1], pc[SET_LO-1:0]};
        end else begin : g_noupper
            assign unused_pc_bits = ^pc[SET_LO-1:0];
        end
    endgenerate

endmodule

// File: rtl/cbp_counter_table.sv
// Table of 2-bit saturating counters with one combinational read port and
// one write port that steps a counter toward an outcome on the clock edge.
// Reads see the contents before any write in the same cycle.
module cbp_counter_table
    import cbp_pkg::*;
#(
    parameter int IDX_W    = 10,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic                          rd_taken,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic                          wr_taken,
    output logic [ENTRIES-1:0][CTR_W-1:0] ctr_all
);

    logic [ENTRIES-1:0][CTR_W-1:0] ctr_q;

    // Guess is the high bit of the addressed counter.
    assign rd_taken = ctr_q[rd_idx][CTR_W-1];
    assign ctr_all  = ctr_q;

    // Initialise all counters to weak not-taken, else train one counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i] <= CTR_WEAK_NT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

endmodule

// File: rtl/corr_branch_predictor.sv
// Correlating branch direction predictor: global outcome history combined
// with branch address selects one 2-bit counter. Lookup is combinational;
// training updates one counter and the history on the clock edge.
// Assumes in-order training so the history at training time matches the
// history the lookup used.
module corr_branch_predictor
    import cbp_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int SET_BITS = 8,
    parameter int HIST_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lookup_pc,
    output logic            lookup_taken,
    input  logic            train_valid,
    input  logic [PC_W-1:0] train_pc,
    input  logic            train_taken
);

    localparam int IDX_W   = SET_BITS + HIST_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W-1:0]             hist;
    logic [IDX_W-1:0]              lookup_idx;
    logic [IDX_W-1:0]              train_idx;
    logic [ENTRIES-1:0][CTR_W-1:0] ctr_view;

    cbp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (train_valid),
        .outcome  (train_taken),
        .hist_q   (hist)
    );

    cbp_index #(.PC_W(PC_W), .SET_BITS(SET_BITS), .HIST_W(HIST_W)) u_lookup_idx (
        .pc   (lookup_pc),
        .hist (hist),
        .idx  (lookup_idx)
    );

    cbp_index #(.PC_W(PC_W), .SET_BITS(SET_BITS), .HIST_W(HIST_W)) u_train_idx (
        .pc   (train_pc),
        .hist (hist),
        .idx  (train_idx)
    );

    cbp_counter_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lookup_idx),
        .rd_taken (lookup_taken),
        .wr_en    (train_valid),
        .wr_idx   (train_idx),
        .wr_taken (train_taken),
        .ctr_all  (ctr_view)
    );

endmodule

// File: rtl/corr_branch_predictor_checker.sv
// Temporal checks on history and counter training, bound to the top module.
module corr_branch_predictor_checker #(
    parameter int HIST_W  = 2,
    parameter int IDX_W   = 10,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      train_valid,
    input  logic                      train_taken,
    input  logic [HIST_W-1:0]         hist,
    input  logic [IDX_W-1:0]          train_idx,
    input  logic [ENTRIES-1:0][1:0]   ctr_view
);

    // R1: history is clear the cycle after reset is seen.
    assert_hist_reset_R1: assert property (@(posedge clk)
        !rst_n |=> hist == '0);

    // R6: a training event shifts its outcome in at bit 0.
    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        train_valid |=> hist[0] == $past(train_taken));

    // R10: idle cycles leave the history untouched.
    assert_hist_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !train_valid |=> $stable(hist));

    // R3: taken never lowers the trained counter and strong taken stays put.
    assert_ctr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && train_taken && ctr_view[train_idx] == 2'b11)
        |=> ctr_view[$past(train_idx)] == 2'b11);

    // R4: not-taken at strong not-taken stays put.
    assert_ctr_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (train_valid && !train_taken && ctr_view[train_idx] == 2'b00)
        |=> ctr_view[$past(train_idx)] == 2'b00);

    // R7: the neighbour slot (other newest-history bit) is not disturbed.
    assert_neighbour_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        train_valid |=> ctr_view[$past(train_idx) ^ IDX_W'(1)]
                        == $past(ctr_view[train_idx ^ IDX_W'(1)]));

    // R10: idle cycles leave the table untouched.
    assert_table_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !train_valid |=> $stable(ctr_view));

endmodule

bind corr_branch_predictor corr_branch_predictor_checker #(
    .HIST_W (HIST_W),
    .IDX_W  (IDX_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .train_valid (train_valid),
    .train_taken (train_taken),
    .hist        (hist),
    .train_idx   (train_idx),
    .ctr_view    (ctr_view)
);

// File: tb/corr_branch_predictor_test.sv
`timescale 1ns/1ps
module corr_branch_predictor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lookup_pc = '0;
    logic        lookup_taken;
    logic        train_valid = 1'b0;
    logic [31:0] train_pc = '0;
    logic        train_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    corr_branch_predictor uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .lookup_pc    (lookup_pc),
        .lookup_taken (lookup_taken),
        .train_valid  (train_valid),
        .train_pc     (train_pc),
        .train_taken  (train_taken)
    );

    localparam logic [31:0] PC_A = 32'h0000_0100;
    localparam logic [31:0] PC_B = 32'h0000_0200;
    localparam logic [31:0] PC_C = 32'h0000_0300;
    localparam logic [31:0] PC_D = 32'h0000_0040;
    localparam logic [31:0] PC_X = 32'h0000_0010;
    localparam logic [31:0] PC_Y = 32'h0000_0014;

    // Vector: {outcome, branch pc, expected guess for same pc afterwards}.
    // Walks one branch through all four history patterns from reset (R2, R3, R4, R6).
    localparam int NVEC = 12;
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b1, PC_A, 1'b0}, {1'b1, PC_A, 1'b0}, {1'b1, PC_A, 1'b1},
        {1'b1, PC_A, 1'b1}, {1'b0, PC_A, 1'b0}, {1'b1, PC_A, 1'b1},
        {1'b0, PC_A, 1'b1}, {1'b0, PC_A, 1'b1}, {1'b0, PC_A, 1'b0},
        {1'b0, PC_A, 1'b0}, {1'b0, PC_A, 1'b0}, {1'b1, PC_A, 1'b0}
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: lookup_taken=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // Look up a pc between edges and compare the guess.
    task automatic probe(input logic [31:0] pc, input logic exp, input string req);
        @(negedge clk);
        lookup_pc = pc;
        #1;
        check(lookup_taken, exp, req);
    endtask

    // One training event lasting one clock edge.
    task automatic train(input logic [31:0] pc, input logic taken);
        @(negedge clk);
        train_valid = 1'b1;
        train_pc    = pc;
        train_taken = taken;
        @(negedge clk);
        train_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // R1: reset state answers not-taken everywhere
        probe(PC_A, 1'b0, "R1");
        probe(32'hFFFF_FFFC, 1'b0, "R1");

        // Vector walk (R2 R3 R4 R6)
        for (int i = 0; i < NVEC; i++) begin
            train(VEC[i][32:1], VEC[i][33]);
            probe(VEC[i][32:1], VEC[i][0], "R2/R3/R4/R6 vector");
        end

        // R7: training under history 00 leaves history 01 slot alone
        do_reset();
        train(PC_A, 1'b1);            // [A,00]=10, hist 01
        train(PC_C, 1'b0);            // hist 10
        train(PC_C, 1'b0);            // hist 00
        probe(PC_A, 1'b1, "R2");
        train(PC_D, 1'b1);            // hist 01
        probe(PC_A, 1'b0, "R7");
        train(PC_D, 1'b0);            // hist 10
        train(PC_D, 1'b0);            // hist 00
        probe(PC_A, 1'b1, "R6");

        // R10: idle cycles with live training data change nothing
        @(negedge clk);
        train_pc = PC_A; train_taken = 1'b0;
        repeat (3) @(negedge clk);
        probe(PC_A, 1'b1, "R10 counter");
        train_taken = 1'b1;
        repeat (3) @(negedge clk);
        probe(PC_A, 1'b1, "R10 history");

        // R8: same-cycle lookup sees old state, then R4 decrement
        @(negedge clk);
        lookup_pc = PC_A; train_valid = 1'b1; train_pc = PC_A; train_taken = 1'b0;
        #1;
        check(lookup_taken, 1'b1, "R8");
        @(negedge clk);
        train_valid = 1'b0;
        #1;
        check(lookup_taken, 1'b0, "R4");

        // R3 saturation, R9 aliasing, R5 hysteresis
        do_reset();
        for (int k = 0; k < 5; k++) train(PC_B, 1'b1);   // [B,11]=11, hist 11
        probe(PC_B, 1'b1, "R3");
        probe(32'h0000_0203, 1'b1, "R9 low bits");
        probe(32'h0000_1200, 1'b1, "R9 high bits");
        probe(32'h0000_0204, 1'b0, "R9 distinct set");
        train(PC_B, 1'b0);            // [B,11]=10, hist 10
        train(PC_C, 1'b1);            // hist 01
        train(PC_C, 1'b1);            // hist 11
        probe(PC_B, 1'b1, "R5 one miss");
        train(PC_B, 1'b0);            // [B,11]=01, hist 10
        train(PC_C, 1'b1);
        train(PC_C, 1'b1);            // hist 11
        probe(PC_B, 1'b0, "R5 two misses");

        // R1: reset mid-run clears history (was 11)
        do_reset();
        train(PC_X, 1'b1);            // lands on [X,00] only if history was 00
        train(PC_Y, 1'b0);
        train(PC_Y, 1'b0);            // hist back to 00
        probe(PC_X, 1'b1, "R1 history");
        probe(PC_B, 1'b0, "R1 counters");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule